// File: doc/BRIEF.md
# Interrupt Translation Table Walker

This block converts an incoming message-signalled interrupt, identified by a device number and an event number, into a physical interrupt number and a target redistributor. To do so it performs three dependent reads of 64-bit entries from memory. The first read gets the device's entry, which locates that device's private translation table. The second read gets the event's entry in that table, which supplies the interrupt number and a collection number. The third read gets the collection's entry, which names the target. Every level checks its identifier range and the valid bit of the entry it fetched. The first failed check ends the walk without any report.

Software-visible configuration arrives as static inputs. These are the identifier width limits, the raw base registers and page sizes of the device and collection tables, the collection-width selection and the target-format flag. A successful walk ends with a one-cycle set-pending pulse that carries the interrupt number and the target. It also updates a status register that holds the last event number translated successfully. Only one memory read is in flight at a time. A new request is taken only while the walker is idle.

Top module: `msi_xlate_walker`

## Requirements
- R1: Every table entry is 8 bytes and sits at table base + identifier*8. The table base is the page-decoded base register for device and collection entries. For translation entries it is device entry bits 51:8 with bits 7:0 zero. Every read address is 8-byte aligned.
- R2: A device number of 2^(cfgDevBits+1) or more ends the walk before any memory read.
- R3: The walk ends after the device read when the event number is 2^(cfgIdBits+1) or more, or when it is 2^R+1 or more, where R is device entry bits 4:0.
- R4: The collection number (translation entry bits 47:32) may use 16 bits when cfgColLimit is 0 and cfgColBits+1 bits otherwise. A wider number ends the walk after two reads.
- R5: The walk ends with no set-pending pulse when bit 63 (valid) of the device, translation or collection entry is clear. It stops after the read that returned that entry.
- R6: For page size code 0 (4 KB) or 1 (16 KB), the base register's bits 47:12 give address bits 47:12. For code 2 (64 KB), register bits 47:16 give address bits 47:16 and register bits 15:12 give address bits 51:48. Lower address bits are zero.
- R7: The target is collection entry bits 50:16. When cfgTargetIsAddr is 1, it is shifted left by 16.
- R8: lastEvent takes the event number only in the cycle after a successful set-pending pulse. Aborted walks leave it unchanged.
- R9: At most one memory read is outstanding. Reads go in the order device, translation, collection, and each read waits for the previous response.
- R10: busy rises in the cycle after a request is accepted. It stays high until the walk completes or aborts. reqReady is low while busy, and requests presented then are ignored.
- R11: On success, setPend is high for exactly one cycle, with setIntId equal to translation entry bits 31:0 and setTarget as in R7. It never occurs outside a walk.
- R12: After reset, busy, setPend and memReqValid are low and lastEvent is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted |
| reqDevId | input | DEV_ID_W | Device number |
| reqEventId | input | EVT_ID_W | Event number |
| cfgDevBits | input | 5 | Device number width minus one |
| cfgIdBits | input | 5 | Event number width minus one |
| cfgColLimit | input | 1 | 1: collection width from cfgColBits |
| cfgColBits | input | 4 | Collection width minus one |
| cfgTargetIsAddr | input | 1 | 1: target is an address (field shifted by 16) |
| cfgDevTblBase | input | 64 | Device table base register |
| cfgDevTblPage | input | 2 | Device table page size code |
| cfgColTblBase | input | 64 | Collection table base register |
| cfgColTblPage | input | 2 | Collection table page size code |
| memReqValid | output | 1 | Read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | ADDR_W | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| busy | output | 1 | Walk in progress |
| setPend | output | 1 | Set-pending pulse |
| setIntId | output | 32 | Interrupt number |
| setTarget | output | TGT_W | Target redistributor index or address |
| lastEvent | output | EVT_ID_W | Last successfully translated event number |

## Verification
The assertions check, on every cycle, the rules that hold regardless of table contents: only one read outstanding, a stalled read request holding its address, aligned read addresses, a set-pending pulse that lasts one cycle and ends the walk, and a status register that moves only after such a pulse. The bench scenarios are the only place to see which level a walk stops at. They count reads for each abort cause: device range, the two event bounds, collection width and each valid bit. They also cover page-size address decoding, the two target formats, and a request ignored during a stalled walk.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;

  // Entry field positions (R1, R3, R4, R5, R7, R11)
  localparam int ValidBit     = 63;
  localparam int IttAddrHi    = 51;
  localparam int IttAddrLo    = 8;
  localparam int RangeHi      = 4;
  localparam int ColIdHi      = 47;
  localparam int ColIdLo      = 32;
  localparam int IntIdHi      = 31;
  localparam int TgtHi        = 50;
  localparam int TgtLo        = 16;
  localparam int ColIdW       = ColIdHi - ColIdLo + 1;
  localparam int TgtFieldW    = TgtHi - TgtLo + 1;

  localparam logic [1:0] Page4k  = 2'd0;
  localparam logic [1:0] Page16k = 2'd1;
  localparam logic [1:0] Page64k = 2'd2;

  typedef enum logic [1:0] {TBL_DEV, TBL_ITT, TBL_COL} tblSel_e;

  typedef struct packed {
    logic    latchReq;
    logic    latchDte;
    logic    latchItte;
    logic    latchCte;
    logic    commit;
    tblSel_e sel;
  } dpStrobe_t;

  // R6: decode a base register into a 52-bit byte address
  function automatic logic [51:0] pageBase(input logic [63:0] r, input logic [1:0] pg);
    logic [51:0] a;
    a = '0;
    if (pg == Page64k) begin
      a[47:16] = r[47:16];
      a[51:48] = r[15:12];
    end else begin
      a[47:12] = r[47:12];
    end
    return a;
  endfunction

endpackage

// File: rtl/msi_xlate_dp.sv
module msi_xlate_dp
  import msi_xlate_pkg::*;
#(
  parameter int DEV_ID_W = 32,
  parameter int EVT_ID_W = 32,
  parameter int ADDR_W   = 52,
  parameter int TGT_W    = 51
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           st,
  input  logic [DEV_ID_W-1:0] reqDevId,
  input  logic [EVT_ID_W-1:0] reqEventId,
  input  logic [4:0]          cfgDevBits,
  input  logic [4:0]          cfgIdBits,
  input  logic                cfgColLimit,
  input  logic [3:0]          cfgColBits,
  input  logic                cfgTargetIsAddr,
  input  logic [63:0]         cfgDevTblBase,
  input  logic [1:0]          cfgDevTblPage,
  input  logic [63:0]         cfgColTblBase,
  input  logic [1:0]          cfgColTblPage,
  input  logic                memReqValid,
  input  logic [63:0]         memRspData,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                devOut,
  output logic                dteBad,
  output logic                itteBad,
  output logic                cteBad,
  output logic [31:0]         setIntId,
  output logic [TGT_W-1:0]    setTarget,
  output logic [EVT_ID_W-1:0] lastEvent
);

  localparam int OffW = ADDR_W - 3;

  logic [DEV_ID_W-1:0] devIdQ;
  logic [EVT_ID_W-1:0] evtIdQ;
  logic [63:0]         dteQ, itteQ, cteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devIdQ    <= '0;
      evtIdQ    <= '0;
      dteQ      <= '0;
      itteQ     <= '0;
      cteQ      <= '0;
      lastEvent <= '0;
    end else begin
      if (st.latchReq) begin
        devIdQ <= reqDevId;
        evtIdQ <= reqEventId;
      end
      if (st.latchDte)  dteQ  <= memRspData;
      if (st.latchItte) itteQ <= memRspData;
      if (st.latchCte)  cteQ  <= memRspData;
      if (st.commit)    lastEvent <= evtIdQ;  // R8
    end
  end

  // R1, R6: entry address per table
  logic [ColIdW-1:0] colId;
  logic [51:0]       devBase, colBase, ittBase;
  assign colId   = itteQ[ColIdHi:ColIdLo];
  assign devBase = pageBase(cfgDevTblBase, cfgDevTblPage);
  assign colBase = pageBase(cfgColTblBase, cfgColTblPage);
  assign ittBase = {dteQ[IttAddrHi:IttAddrLo], 8'h00};

  always_comb begin
    unique case (st.sel)
      TBL_DEV: memReqAddr = ADDR_W'(devBase) + {OffW'(devIdQ), 3'b000};
      TBL_ITT: memReqAddr = ADDR_W'(ittBase) + {OffW'(evtIdQ), 3'b000};
      default: memReqAddr = ADDR_W'(colBase) + {OffW'(colId), 3'b000};
    endcase
  end

  // R2, R3, R4, R5: range and valid checks
  logic [4:0] colW;
  assign colW    = cfgColLimit ? 5'(cfgColBits) + 5'd1 : 5'd16;
  assign devOut  = (64'(devIdQ) >> (7'(cfgDevBits) + 7'd1)) != 64'd0;
  assign dteBad  = !dteQ[ValidBit]
                || ((64'(evtIdQ) >> (7'(cfgIdBits) + 7'd1)) != 64'd0)
                || (64'(evtIdQ) > (64'd1 << dteQ[RangeHi:0]));
  assign itteBad = !itteQ[ValidBit] || ((32'(colId) >> colW) != 32'd0);
  assign cteBad  = !cteQ[ValidBit];

  // R7, R11
  logic [TgtFieldW-1:0] tgtField;
  assign tgtField  = cteQ[TgtHi:TgtLo];
  assign setIntId  = itteQ[IntIdHi:0];
  assign setTarget = cfgTargetIsAddr ? TGT_W'({tgtField, 16'h0000}) : TGT_W'(tgtField);

  // R1
  // addr_align_chk
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);

  // R8
  // status_hold_chk
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.commit) |-> $stable(lastEvent));

endmodule

// File: rtl/msi_xlate_ctrl.sv
module msi_xlate_ctrl
  import msi_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      memReqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      devOut,
  input  logic      dteBad,
  input  logic      itteBad,
  input  logic      cteBad,
  output logic      busy,
  output logic      setPend,
  output dpStrobe_t st
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV_REQ, S_DEV_WAIT, S_ITT_REQ, S_ITT_WAIT, S_COL_REQ, S_COL_WAIT, S_FIN
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  logic abortNow;
  always_comb begin
    abortNow = ((state == S_DEV_REQ) && devOut)
            || ((state == S_ITT_REQ) && dteBad)
            || ((state == S_COL_REQ) && itteBad);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:     if (reqValid) nextState = S_DEV_REQ;
      S_DEV_REQ:  if (abortNow) nextState = S_IDLE; else if (memReqReady) nextState = S_DEV_WAIT;
      S_DEV_WAIT: if (memRspValid) nextState = S_ITT_REQ;
      S_ITT_REQ:  if (abortNow) nextState = S_IDLE; else if (memReqReady) nextState = S_ITT_WAIT;
      S_ITT_WAIT: if (memRspValid) nextState = S_COL_REQ;
      S_COL_REQ:  if (abortNow) nextState = S_IDLE; else if (memReqReady) nextState = S_COL_WAIT;
      S_COL_WAIT: if (memRspValid) nextState = S_FIN;
      default:    nextState = S_IDLE;
    endcase
  end

  always_comb begin
    reqReady    = (state == S_IDLE);
    busy        = (state != S_IDLE);
    memReqValid = !abortNow && ((state == S_DEV_REQ) || (state == S_ITT_REQ) || (state == S_COL_REQ));
    st.latchReq  = (state == S_IDLE) && reqValid;
    st.latchDte  = (state == S_DEV_WAIT) && memRspValid;
    st.latchItte = (state == S_ITT_WAIT) && memRspValid;
    st.latchCte  = (state == S_COL_WAIT) && memRspValid;
    st.commit    = (state == S_FIN) && !cteBad;
    if (state == S_ITT_REQ || state == S_ITT_WAIT)      st.sel = TBL_ITT;
    else if (state == S_COL_REQ || state == S_COL_WAIT) st.sel = TBL_COL;
    else                                                st.sel = TBL_DEV;
    setPend = st.commit;
  end

  // R9
  // one_outstanding_chk
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R11
  // pend_single_chk
  pend_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    setPend |=> (!setPend && !busy));

  // R11
  // pend_in_walk_chk
  pend_in_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    setPend |-> $past(busy));

endmodule

// File: rtl/msi_xlate_walker.sv
module msi_xlate_walker
  import msi_xlate_pkg::*;
#(
  parameter int DEV_ID_W = 32,
  parameter int EVT_ID_W = 32,
  parameter int ADDR_W   = 52,
  parameter int TGT_W    = 51
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [DEV_ID_W-1:0] reqDevId,
  input  logic [EVT_ID_W-1:0] reqEventId,
  input  logic [4:0]          cfgDevBits,
  input  logic [4:0]          cfgIdBits,
  input  logic                cfgColLimit,
  input  logic [3:0]          cfgColBits,
  input  logic                cfgTargetIsAddr,
  input  logic [63:0]         cfgDevTblBase,
  input  logic [1:0]          cfgDevTblPage,
  input  logic [63:0]         cfgColTblBase,
  input  logic [1:0]          cfgColTblPage,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [63:0]         memRspData,
  output logic                busy,
  output logic                setPend,
  output logic [31:0]         setIntId,
  output logic [TGT_W-1:0]    setTarget,
  output logic [EVT_ID_W-1:0] lastEvent
);

  dpStrobe_t st;
  logic devOut, dteBad, itteBad, cteBad;

  msi_xlate_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .memReqValid, .memReqReady, .memRspValid,
    .devOut, .dteBad, .itteBad, .cteBad, .busy, .setPend, .st
  );

  msi_xlate_dp #(
    .DEV_ID_W(DEV_ID_W), .EVT_ID_W(EVT_ID_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W)
  ) u_dp (
    .clk, .rstN, .st, .reqDevId, .reqEventId, .cfgDevBits, .cfgIdBits, .cfgColLimit,
    .cfgColBits, .cfgTargetIsAddr, .cfgDevTblBase, .cfgDevTblPage, .cfgColTblBase,
    .cfgColTblPage, .memReqValid, .memRspData, .memReqAddr, .devOut, .dteBad, .itteBad,
    .cteBad, .setIntId, .setTarget, .lastEvent
  );

  // R9
  // req_hold_chk
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

// File: tb/test_msi_xlate_walker.sv
module test_msi_xlate_walker;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqDevId = '0, reqEventId = '0;
  logic [4:0]  cfgDevBits = 5'd7, cfgIdBits = 5'd15;
  logic        cfgColLimit = 1'b0;
  logic [3:0]  cfgColBits = 4'd0;
  logic        cfgTargetIsAddr = 1'b0;
  logic [63:0] cfgDevTblBase = 64'h1000_0000;
  logic [1:0]  cfgDevTblPage = 2'd0;
  logic [63:0] cfgColTblBase = 64'h2000_0000;
  logic [1:0]  cfgColTblPage = 2'd0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        busy, setPend;
  logic [31:0] setIntId;
  logic [50:0] setTarget;
  logic [31:0] lastEvent;

  int checks = 0, errors = 0;
  int readCount = 0, pendCount = 0;
  longint unsigned firstAddr;
  longint unsigned pendInt, pendTgt;
  logic [63:0] mem [longint unsigned];

  always #(ClkPeriod / 2) clk = ~clk;

  msi_xlate_walker i_msi_xlate_walker (.*);

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem.exists(64'(memReqAddr)) ? mem[64'(memReqAddr)] : 64'd0;
      if (readCount == 0) firstAddr = 64'(memReqAddr);
      readCount = readCount + 1;
    end
  end

  always @(negedge clk) begin
    if (setPend) begin
      pendCount = pendCount + 1;
      pendInt   = 64'(setIntId);
      pendTgt   = 64'(setTarget);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkDte(bit v, logic [51:0] itt, logic [4:0] rng);
    logic [63:0] e = '0;
    e[63] = v; e[51:8] = itt[51:8]; e[4:0] = rng;
    return e;
  endfunction
  function automatic logic [63:0] mkItte(bit v, logic [15:0] col, logic [31:0] intId);
    logic [63:0] e = '0;
    e[63] = v; e[47:32] = col; e[31:0] = intId;
    return e;
  endfunction
  function automatic logic [63:0] mkCte(bit v, logic [34:0] tgt);
    logic [63:0] e = '0;
    e[63] = v; e[50:16] = tgt;
    return e;
  endfunction

  localparam longint unsigned IttBase = 64'h3000_0000;

  task automatic runWalk(input logic [31:0] dev, input logic [31:0] evt);
    readCount = 0;
    pendCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqDevId = dev; reqEventId = evt;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R12", "busy", 64'(busy), 0);
    check(setPend == 1'b0, "R12", "setPend", 64'(setPend), 0);
    check(memReqValid == 1'b0, "R12", "memReqValid", 64'(memReqValid), 0);
    check(lastEvent == 32'd0, "R12", "lastEvent", 64'(lastEvent), 0);
  endtask

  task automatic testSuccess();
    runWalk(3, 5);
    check(readCount == 3, "R9", "read count", readCount, 3);
    check(firstAddr == 64'h1000_0018, "R1", "device entry address", firstAddr, 64'h1000_0018);
    check(pendCount == 1, "R11", "pulse count", pendCount, 1);
    check(pendInt == 8200, "R11", "intId", pendInt, 8200);
    check(pendTgt == 7, "R7", "index target", pendTgt, 7);
    check(lastEvent == 5, "R8", "lastEvent", 64'(lastEvent), 5);
  endtask

  task automatic testDevRange();
    runWalk(256, 5);   // devBits=7 -> limit 256
    check(readCount == 0, "R2", "reads for device 256", readCount, 0);
    check(pendCount == 0, "R2", "pulses", pendCount, 0);
    check(lastEvent == 5, "R8", "lastEvent after abort", 64'(lastEvent), 5);
    runWalk(255, 5);   // in range, no entry -> one read then invalid
    check(readCount == 1, "R2", "reads for device 255", readCount, 1);
  endtask

  task automatic testEvtRange();
    runWalk(3, 17);    // range 4 -> 17 is out
    check(readCount == 1, "R3", "reads for event 17", readCount, 1);
    check(pendCount == 0, "R3", "pulses event 17", pendCount, 0);
    runWalk(3, 16);
    check(pendCount == 1 && pendInt == 9000, "R3", "event 16 intId", pendInt, 9000);
    check(lastEvent == 16, "R8", "lastEvent", 64'(lastEvent), 16);
    cfgIdBits = 5'd3;  // limit 16
    runWalk(3, 16);
    check(readCount == 1 && pendCount == 0, "R3", "reads with idBits 3", readCount, 1);
    cfgIdBits = 5'd15;
  endtask

  task automatic testColRange();
    cfgColLimit = 1'b1; cfgColBits = 4'd4;   // 5 bits -> 40 is out
    runWalk(3, 6);
    check(readCount == 2 && pendCount == 0, "R4", "reads with 5-bit collection", readCount, 2);
    cfgColLimit = 1'b0;
    runWalk(3, 6);
    check(readCount == 3 && pendTgt == 9, "R4", "target with 16-bit collection", pendTgt, 9);
  endtask

  task automatic testValid();
    runWalk(4, 1);
    check(readCount == 1 && pendCount == 0, "R5", "reads invalid device entry", readCount, 1);
    runWalk(3, 7);
    check(readCount == 2 && pendCount == 0, "R5", "reads invalid translation entry", readCount, 2);
    runWalk(3, 8);
    check(readCount == 3 && pendCount == 0, "R5", "reads invalid collection entry", readCount, 3);
    check(lastEvent == 6, "R8", "lastEvent after aborts", 64'(lastEvent), 6);
  endtask

  task automatic testPage();
    longint unsigned a64;
    a64 = (64'h3 << 48) | 64'h1234_0000;
    mem[a64 + 24] = mkDte(1, IttBase, 4);
    cfgDevTblPage = 2'd2; cfgDevTblBase = 64'h0000_0000_1234_3ABC;
    runWalk(3, 5);
    check(firstAddr == a64 + 24, "R6", "64K page address", firstAddr, a64 + 24);
    check(pendCount == 1, "R6", "64K walk pulse", pendCount, 1);
    cfgDevTblPage = 2'd1; cfgDevTblBase = 64'h1000_0FFF;
    runWalk(3, 5);
    check(firstAddr == 64'h1000_0018, "R6", "16K page address", firstAddr, 64'h1000_0018);
    cfgDevTblPage = 2'd0; cfgDevTblBase = 64'h1000_0000;
  endtask

  task automatic testTargetAddr();
    cfgTargetIsAddr = 1'b1;
    runWalk(3, 5);
    check(pendTgt == (64'd7 << 16), "R7", "address target", pendTgt, 64'd7 << 16);
    cfgTargetIsAddr = 1'b0;
  endtask

  task automatic testBusy();
    readCount = 0; pendCount = 0;
    memReqReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqDevId = 3; reqEventId = 16;
    @(negedge clk);
    reqDevId = 4; reqEventId = 1;      // held while busy: must be ignored
    check(busy == 1'b1, "R10", "busy after accept", 64'(busy), 1);
    repeat (3) @(negedge clk);
    check(reqReady == 1'b0, "R10", "reqReady while busy", 64'(reqReady), 0);
    check(memReqValid == 1'b1 && readCount == 0, "R9", "stalled request", readCount, 0);
    reqValid = 1'b0;
    memReqReady = 1'b1;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
    check(readCount == 3 && pendCount == 1, "R10", "reads of first walk", readCount, 3);
    check(pendInt == 9000 && lastEvent == 16, "R10", "first request result", pendInt, 9000);
  endtask

  initial begin
    mem[64'h1000_0018]     = mkDte(1, IttBase, 4);
    mem[IttBase + 5 * 8]   = mkItte(1, 2, 8200);
    mem[IttBase + 16 * 8]  = mkItte(1, 2, 9000);
    mem[IttBase + 6 * 8]   = mkItte(1, 40, 8300);
    mem[IttBase + 8 * 8]   = mkItte(1, 3, 8400);
    mem[64'h2000_0000 + 2 * 8]  = mkCte(1, 7);
    mem[64'h2000_0000 + 40 * 8] = mkCte(1, 9);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSuccess();
    testDevRange();
    testEvtRange();
    testColRange();
    testValid();
    testPage();
    testTargetAddr();
    testBusy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule